// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Sequencer

This block connects a simple synchronous request port to an external asynchronous static RAM that has an active-low chip enable and an active-low write enable. The requester presents one read or write at a time with an address and, for writes, the data. The sequencer then walks the memory pins through the required order of phases. For a read, write enable is held high, the address is set up, and chip enable is lowered. For a write, write enable is lowered, the address is set up, the data is driven, and chip enable is lowered last. Each phase lasts at least one clock, and all pins come from registers.

The access time of a read and the hold time of a write are parameters counted in clock cycles. After a read, the captured byte appears on the read port together with a one-cycle valid pulse. After a write, a one-cycle done pulse is raised. Between cycles the memory pins are parked in the idle state, and the requester waits for the ready output before it presents the next request.

Top module: `sram_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, mem_ce_n and mem_we_n are 1, ready is 1, rd_valid and wr_done are 0, and the data bus driver is off.
- R2: On a read, mem_we_n is already 1 and mem_addr already holds the requested address, with mem_ce_n still 1, in the cycle before mem_ce_n falls. mem_addr does not change while mem_ce_n is 0.
- R3: On a read, mem_ce_n stays 0 for exactly ACCESS_CYC cycles. The bus is sampled at the edge that ends that span. rd_valid is 1 for one cycle, starting ACCESS_CYC+2 cycles after the accepting edge, and it carries the sampled byte on rd_data.
- R4: On a write, mem_we_n falls first. mem_addr changes to the requested address only after mem_we_n is 0. The write data is on mem_dq in the cycle before mem_ce_n falls, and mem_we_n does not change while mem_ce_n is 0.
- R5: On a write, mem_ce_n stays 0 for exactly HOLD_CYC cycles, and it rises while mem_we_n is still 0. wr_done is 1 for one cycle, starting HOLD_CYC+4 cycles after the accepting edge.
- R6: The data bus driver is on only while mem_we_n is 0. While mem_ce_n is 0 in a write, mem_dq carries the requested write data.
- R7: ready is 0 from the accepting edge until the cycle is over. ready returns to 1 one cycle after rd_valid or wr_done, and only with mem_ce_n and mem_we_n both 1. rd_valid and wr_done are never 1 together.
- R8: A request presented while ready is 0 is ignored. It starts no memory cycle and changes no stored byte.
- R9: A byte written to an address is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted on an edge where ready is 1 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| ready | output | 1 | Idle and able to accept a request |
| rd_valid | output | 1 | One-cycle pulse: rd_data is valid |
| rd_data | output | DW | Byte sampled from the memory |
| wr_done | output | 1 | One-cycle pulse: write cycle finished |
| mem_addr | output | AW | Memory address bus |
| mem_dq | inout | DW | Memory data bus, driven only during writes |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |

## Verification
The hardest case to reach from the ports is a design that samples the bus too early or releases chip enable too soon. A real memory hides both errors, because it holds data long after enable. The bench's memory model therefore returns the inverted byte until it has counted ACCESS_CYC falling edges with chip enable low. It also reports the length of the chip-enable pulse on every write commit, so a timing error of one cycle shows up as a wrong read value or as a failed hold-count check. Ignored requests are forced by raising a conflicting write request in the cycle right after a read is accepted. That request is withdrawn just before ready returns, and the targeted address is read back later.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_WE,
    ST_RD_ADR,
    ST_RD_ACC,
    ST_WR_WE,
    ST_WR_ADR,
    ST_WR_DAT,
    ST_WR_CE,
    ST_WR_END,
    ST_END
  } seq_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe;
  } pin_set_t;

  function automatic pin_set_t pins_of(seq_state_e s);
    pin_set_t p;
    p.ce_n = !(s == ST_RD_ACC || s == ST_WR_CE);
    p.we_n = !(s == ST_WR_WE || s == ST_WR_ADR || s == ST_WR_DAT ||
               s == ST_WR_CE || s == ST_WR_END);
    p.oe   = (s == ST_WR_DAT || s == ST_WR_CE || s == ST_WR_END);
    return p;
  endfunction

  function automatic logic loads_addr(seq_state_e s);
    return (s == ST_RD_ADR || s == ST_WR_ADR);
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ACCESS_CYC = 2,
  parameter int HOLD_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_write,
  output seq_state_e nxt,
  output logic       accept,
  output logic       capture,
  output logic       wr_fin
);

  localparam int MAXC = (ACCESS_CYC > HOLD_CYC) ? ACCESS_CYC : HOLD_CYC;
  localparam int CW   = $clog2(MAXC) + 1;

  seq_state_e    state_q;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_done;

  sram_seq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) nxt = req_write ? ST_WR_WE : ST_RD_WE;
      ST_RD_WE:  nxt = ST_RD_ADR;
      ST_RD_ADR: nxt = ST_RD_ACC;
      ST_RD_ACC: if (tmr_done) nxt = ST_END;
      ST_WR_WE:  nxt = ST_WR_ADR;
      ST_WR_ADR: nxt = ST_WR_DAT;
      ST_WR_DAT: nxt = ST_WR_CE;
      ST_WR_CE:  if (tmr_done) nxt = ST_WR_END;
      ST_WR_END: nxt = ST_END;
      ST_END:    nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state_q == ST_RD_ADR) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(ACCESS_CYC - 1);
    end else if (state_q == ST_WR_DAT) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(HOLD_CYC - 1);
    end
  end

  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign capture = (state_q == ST_RD_ACC) && tmr_done;
  assign wr_fin  = (state_q == ST_WR_END);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= nxt;
  end

endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
  import sram_seq_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_e    nxt,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic          wr_fin,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out,
  output logic          ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          wr_done
);

  pin_set_t      pins_nxt;
  logic [AW-1:0] addr_hold;

  assign pins_nxt = pins_of(nxt);

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_hold <= req_addr;
      dq_out    <= req_wdata;
    end
    if (loads_addr(nxt)) mem_addr <= addr_hold;
    if (capture)         rd_data  <= dq_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      dq_oe    <= 1'b0;
      ready    <= 1'b1;
      rd_valid <= 1'b0;
      wr_done  <= 1'b0;
    end else begin
      mem_ce_n <= pins_nxt.ce_n;
      mem_we_n <= pins_nxt.we_n;
      dq_oe    <= pins_nxt.oe;
      ready    <= (nxt == ST_IDLE);
      rd_valid <= capture;
      wr_done  <= wr_fin;
    end
  end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int AW         = 4,
  parameter int DW         = 8,
  parameter int ACCESS_CYC = 2,
  parameter int HOLD_CYC   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          wr_done,
  output logic [AW-1:0] mem_addr,
  inout  wire  [DW-1:0] mem_dq,
  output logic          mem_ce_n,
  output logic          mem_we_n
);

  seq_state_e    nxt;
  logic          accept;
  logic          capture;
  logic          wr_fin;
  logic          dq_oe;
  logic [DW-1:0] dq_out;

  sram_seq_ctrl #(
    .ACCESS_CYC (ACCESS_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .nxt       (nxt),
    .accept    (accept),
    .capture   (capture),
    .wr_fin    (wr_fin)
  );

  sram_seq_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .nxt       (nxt),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .wr_fin    (wr_fin),
    .dq_in     (mem_dq),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out),
    .ready     (ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .wr_done   (wr_done)
  );

  assign mem_dq = dq_oe ? dq_out : {DW{1'bz}};

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int AW         = 4,
  parameter int ACCESS_CYC = 2,
  parameter int HOLD_CYC   = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic          dq_oe,
  input logic          ready,
  input logic          rd_valid,
  input logic          wr_done
);

  logic [15:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || mem_ce_n)      low_cnt <= '0;
    else if (low_cnt != '1)   low_cnt <= low_cnt + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (mem_ce_n && mem_we_n && ready && !dq_oe && !rd_valid && !wr_done));

  assert_addr_steady_R2: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> $stable(mem_addr));

  assert_access_span_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (mem_ce_n && low_cnt == 16'(ACCESS_CYC)));

  assert_we_steady_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> $stable(mem_we_n));

  assert_hold_span_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_ce_n) && !mem_we_n) |-> (low_cnt == 16'(HOLD_CYC)));

  assert_drive_in_write_R6: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !mem_we_n);

  assert_ready_idle_pins_R7: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mem_ce_n && mem_we_n && !dq_oe));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && wr_done));

  assert_done_then_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid || wr_done) |=> ready);

endmodule

bind sram_seq sram_seq_chk #(
  .AW         (AW),
  .ACCESS_CYC (ACCESS_CYC),
  .HOLD_CYC   (HOLD_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_ce_n (mem_ce_n),
  .mem_we_n (mem_we_n),
  .mem_addr (mem_addr),
  .dq_oe    (dq_oe),
  .ready    (ready),
  .rd_valid (rd_valid),
  .wr_done  (wr_done)
);

// File: tb/sram_seq_test.sv
module sram_seq_test;

  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int ACC = 3;
  localparam int HLD = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          ready, rd_valid, wr_done, mem_ce_n, mem_we_n;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  sram_seq #(.AW(AW), .DW(DW), .ACCESS_CYC(ACC), .HOLD_CYC(HLD)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done),
    .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: returns inverted data until the access time has passed
  logic [DW-1:0] sram [16];
  logic [DW-1:0] exp_mem [16];
  int            ce_cnt = 0;
  logic          p_ce = 1'b1, p_we = 1'b1;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;
  bit            cur_write = 1'b0;
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] cur_wd = '0;
  int            cycles_started = 0;

  assign mem_dq = (!mem_ce_n && mem_we_n) ?
                  ((ce_cnt >= ACC) ? sram[mem_addr] : ~sram[mem_addr]) : {DW{1'bz}};

  always @(negedge clk) begin
    if (!rst) begin
      if (p_ce && !mem_ce_n) begin
        cycles_started++;
        if (cur_write) begin
          chk(p_we == 1'b0, "R4 we low before ce", p_we, 0);
          chk(p_addr == cur_addr, "R4 addr before ce", p_addr, cur_addr);
          chk(p_dq == cur_wd, "R4 data before ce", p_dq, cur_wd);
        end else begin
          chk(p_we == 1'b1, "R2 we high before ce", p_we, 1);
          chk(p_addr == cur_addr, "R2 addr before ce", p_addr, cur_addr);
        end
      end
      if (mem_addr != p_addr) begin
        chk(mem_we_n == !cur_write && p_we == !cur_write && mem_ce_n,
            cur_write ? "R4 addr after we" : "R2 addr after we", mem_we_n, !cur_write);
      end
      if (!mem_ce_n && !mem_we_n)
        chk(mem_dq == cur_wd, "R6 write data on bus", mem_dq, cur_wd);
      if (!p_ce && mem_ce_n && !mem_we_n) begin
        chk(ce_cnt == HLD, "R5 ce low span", ce_cnt, HLD);
        sram[mem_addr] = mem_dq;
      end
    end
    ce_cnt <= mem_ce_n ? 0 : ce_cnt + 1;
    p_ce   <= mem_ce_n;
    p_we   <= mem_we_n;
    p_addr <= mem_addr;
    p_dq   <= mem_dq;
  end

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit poke);
    int n;
    int start_cnt;
    while (!ready) @(negedge clk);
    cur_write = wr; cur_addr = a; cur_wd = d;
    start_cnt = cycles_started;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    n = 1;
    chk(ready == 1'b0, "R7 ready low in cycle", ready, 0);
    if (poke) begin
      req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 4'h5; req_wdata = 8'hEE;
    end else begin
      req_valid = 1'b0;
    end
    while (!(wr ? wr_done : rd_valid) && n < 60) begin
      chk(!(rd_valid || wr_done), "R7 no stray pulse", rd_valid, 0);
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    if (wr) begin
      chk(n == HLD + 5, "R5 wr_done latency", n, HLD + 5);
      exp_mem[a] = d;
    end else begin
      chk(n == ACC + 3, "R3 rd_valid latency", n, ACC + 3);
      chk(rd_data == exp_mem[a], "R9 read data", rd_data, exp_mem[a]);
    end
    chk(!(rd_valid && wr_done), "R7 one pulse kind", rd_valid, 0);
    @(negedge clk);
    chk(!rd_valid && !wr_done, "R3 pulse one cycle", rd_valid | wr_done, 0);
    chk(ready && mem_ce_n && mem_we_n, "R7 idle on ready", {ready, mem_ce_n, mem_we_n}, 7);
    chk(cycles_started == start_cnt + 1, "R8 one memory cycle", cycles_started - start_cnt, 1);
    if (poke) begin
      @(negedge clk);
      chk(mem_we_n && mem_ce_n && ready, "R8 ignored req started nothing",
          {mem_we_n, mem_ce_n, ready}, 7);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      sram[i]    = 8'(i * 13 + 7);
      exp_mem[i] = 8'(i * 13 + 7);
    end
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && ready && !rd_valid && !wr_done, "R1 reset state",
        {mem_ce_n, mem_we_n, ready, rd_valid, wr_done}, 5'b11100);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && ready, "R1 after reset", {mem_ce_n, mem_we_n, ready}, 7);

    for (int a = 0; a < 16; a++) do_op(1'b0, 4'(a), 8'h00, 1'b0);
    for (int a = 0; a < 16; a++) do_op(1'b1, 4'(a), 8'(a * 37 + 5), 1'b0);
    for (int a = 15; a >= 0; a--) do_op(1'b0, 4'(a), 8'h00, 1'b0);
    for (int a = 0; a < 16; a++) begin
      do_op(1'b1, 4'(a), 8'(a * 91 + 200), 1'b0);
      do_op(1'b0, 4'(a ^ 9), 8'h00, 1'b0);
    end
    // R8: conflicting write presented while busy must be dropped
    do_op(1'b0, 4'h3, 8'h00, 1'b1);
    do_op(1'b0, 4'h3 ^ 4'h5, 8'h00, 1'b0);
    do_op(1'b0, 4'hA, 8'h00, 1'b1);
    do_op(1'b0, 4'hA ^ 4'h5, 8'h00, 1'b0);
    do_op(1'b1, 4'hF, 8'h00, 1'b0);
    do_op(1'b0, 4'hF, 8'h00, 1'b0);
    do_op(1'b1, 4'h0, 8'hFF, 1'b0);
    do_op(1'b0, 4'h0, 8'h00, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule